// File: doc/BRIEF.md
# USB Host Channel Interrupt Status

This block keeps the interrupt status word of one host channel in a USB host controller. The channel's transaction engine and its DMA engine send single-cycle event pulses (handshakes received, errors detected, descriptor progress). The block turns each pulse into a sticky status bit. Software reads the bits over a small register bus and clears them by writing ones.

The meaning of several bits depends on whether the channel runs with descriptor-list (scatter/gather) DMA. In that mode the handshake and per-packet error bits still record events but are kept off the interrupt line. Three bits exist only in that mode: buffer not available, excessive transaction error and list rollover. The channel-halted and transfer-complete bits are derived from descriptor flags. An internal counter tracks transaction errors in a row and flags the excessive-error condition on the third one.

A per-bit enable register lets software pick which allowed bits drive the single channel interrupt output.

Top module: `usb_hc_chan_irq`

## Requirements
- R1: The bus has word address 0 for status and word address 1 for enable. Status bit positions are: 0 transfer complete, 1 channel halted, 2 bus error, 3 STALL, 4 NAK, 5 ACK, 6 NYET, 7 transaction error, 8 babble, 9 frame overrun, 10 data toggle error, 11 buffer not available, 12 excessive transaction error, 13 list rollover. Bits 31:14 of both words read 0. Writes to enable bits 31:14 are dropped. Addresses 2 and 3 read 0 and ignore writes.
- R2: Status bits are set only by events. A write to address 0 clears every bit written as 1 and leaves bits written as 0 unchanged. Status and enable reset to 0. A set appears in the readback on the cycle after its event.
- R3: If an event sets a bit in the same cycle that software writes 1 to it, the bit ends up set.
- R4: With scatter/gather mode on, bits 3 to 10 still latch but never assert chan_irq.
- R5: Bits 11, 12 and 13 never set while scatter/gather mode is off. While it is off they read as 0 and do not drive chan_irq.
- R6: In scatter/gather mode on a non-isochronous channel, the third transaction error in a row sets bit 12. The error run count returns to 0 on ev_ack or ev_data_rx, and this clear beats an error in the same cycle. The count also returns to 0 when it reaches three, whatever the mode.
- R7: Bit 11 sets from ev_desc_notready only in scatter/gather mode on a non-isochronous channel. Bit 12 never sets for an isochronous channel.
- R8: In scatter/gather mode, bit 1 sets when any of these occurs: a descriptor completes with its end-of-list flag, bit 2 sets, bit 12 sets, ev_babble, or ev_stall. Outside that mode, bit 1 sets from ev_halt_req.
- R9: In scatter/gather mode, bit 0 sets when a descriptor completes with its interrupt-on-complete flag. Outside that mode, bit 0 sets from ev_xfer_ok.
- R10: Bit 2 sets from ev_bus_err only while dma_en is 1.
- R11: chan_irq is the OR of the status bits that are both enabled and allowed by the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sg_mode | input | 1 | Scatter/gather descriptor DMA mode |
| dma_en | input | 1 | Internal DMA active |
| iso_chan | input | 1 | Channel is isochronous |
| ev_xfer_ok | input | 1 | Transfer ended without error (non-SG) |
| ev_desc_done | input | 1 | Descriptor processing finished |
| ev_desc_ioc | input | 1 | Finished descriptor has interrupt-on-complete |
| ev_desc_eol | input | 1 | Finished descriptor has end-of-list |
| ev_halt_req | input | 1 | Channel halted (non-SG) |
| ev_bus_err | input | 1 | System bus error during DMA |
| ev_stall | input | 1 | STALL received |
| ev_nak | input | 1 | NAK received |
| ev_ack | input | 1 | ACK received or sent |
| ev_nyet | input | 1 | NYET received |
| ev_xact_err | input | 1 | Transaction error |
| ev_babble | input | 1 | Babble detected |
| ev_frm_ovr | input | 1 | Frame overrun |
| ev_tgl_err | input | 1 | Data toggle mismatch |
| ev_desc_notready | input | 1 | Fetched descriptor not ready |
| ev_list_roll | input | 1 | Descriptor list rolled over |
| ev_data_rx | input | 1 | Data packet received successfully |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| chan_irq | output | 1 | Channel interrupt |

## Verification
The case most likely to hide a bug is a hardware event and a software write-1 clear hitting the same status bit in one cycle. The bench provokes it directly, by pulsing a STALL while clearing that same bit. It also provokes it at random throughout a long sweep of mixed events and bus writes. A bench model that gives priority to the set judges each result. A second same-cycle case is a transaction error that coincides with a successful handshake. The bench checks that the handshake wins and that the third error after it raises nothing.

// File: rtl/usb_hcirq_pkg.sv
package usb_hcirq_pkg;
  localparam int STAT_W = 14;
  localparam int REG_W  = 32;

  localparam int B_XFER   = 0;
  localparam int B_HALT   = 1;
  localparam int B_BUSERR = 2;
  localparam int B_STALL  = 3;
  localparam int B_NAK    = 4;
  localparam int B_ACK    = 5;
  localparam int B_NYET   = 6;
  localparam int B_XACT   = 7;
  localparam int B_BABBLE = 8;
  localparam int B_FRMOVR = 9;
  localparam int B_TOGGLE = 10;
  localparam int B_BNA    = 11;
  localparam int B_XCS    = 12;
  localparam int B_ROLL   = 13;

  typedef logic [STAT_W-1:0] stat_t;

  typedef struct packed {
    logic xfer_ok;
    logic desc_done;
    logic desc_ioc;
    logic desc_eol;
    logic halt_req;
    logic bus_err;
    logic stall;
    logic nak;
    logic ack;
    logic nyet;
    logic xact_err;
    logic babble;
    logic frm_ovr;
    logic tgl_err;
    logic desc_notready;
    logic list_roll;
    logic data_rx;
  } chan_ev_t;

  // bits that exist only with descriptor-list DMA
  function automatic stat_t sg_only_bits();
    stat_t m;
    m = '0;
    for (int i = B_BNA; i <= B_ROLL; i++) m[i] = 1'b1;
    return m;
  endfunction

  // per-packet bits kept off the interrupt in descriptor-list DMA
  function automatic stat_t pkt_bits();
    stat_t m;
    m = '0;
    for (int i = B_STALL; i <= B_TOGGLE; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic stat_t irq_allow(input logic sg);
    return sg ? ~pkt_bits() : ~sg_only_bits();
  endfunction

  function automatic stat_t read_view(input logic sg, input stat_t q);
    return sg ? q : (q & ~sg_only_bits());
  endfunction

  function automatic logic w1c_next(input logic q, input logic clr, input logic set);
    return (q & ~clr) | set;
  endfunction
endpackage

// File: rtl/hcirq_err_counter.sv
module hcirq_err_counter #(
  parameter int LIMIT = 3,
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err,
  input  logic             ok,
  output logic             hit,
  output logic [CNT_W-1:0] cnt
);
  logic at_last;

  assign at_last = (cnt == CNT_W'(LIMIT - 1));
  assign hit     = err & ~ok & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (ok)       cnt <= '0;
    else if (err) begin
      if (at_last)     cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hcirq_set_logic.sv
module hcirq_set_logic
  import usb_hcirq_pkg::*;
(
  input  chan_ev_t ev,
  input  logic     sg,
  input  logic     dma_en,
  input  logic     iso,
  input  logic     run_hit,
  output stat_t    set_vec
);
  logic bus_err_ok, xcs_set, bna_set, halt_sg;

  assign bus_err_ok = ev.bus_err & dma_en;
  assign xcs_set    = sg & ~iso & run_hit;
  assign bna_set    = sg & ~iso & ev.desc_notready;
  assign halt_sg    = (ev.desc_done & ev.desc_eol) | bus_err_ok | xcs_set
                    | ev.babble | ev.stall;

  always_comb begin
    set_vec           = '0;
    set_vec[B_XFER]   = sg ? (ev.desc_done & ev.desc_ioc) : ev.xfer_ok;
    set_vec[B_HALT]   = sg ? halt_sg : ev.halt_req;
    set_vec[B_BUSERR] = bus_err_ok;
    set_vec[B_STALL]  = ev.stall;
    set_vec[B_NAK]    = ev.nak;
    set_vec[B_ACK]    = ev.ack;
    set_vec[B_NYET]   = ev.nyet;
    set_vec[B_XACT]   = ev.xact_err;
    set_vec[B_BABBLE] = ev.babble;
    set_vec[B_FRMOVR] = ev.frm_ovr;
    set_vec[B_TOGGLE] = ev.tgl_err;
    set_vec[B_BNA]    = bna_set;
    set_vec[B_XCS]    = xcs_set;
    set_vec[B_ROLL]   = sg & ev.list_roll;
  end
endmodule

// File: rtl/hcirq_status_reg.sv
module hcirq_status_reg #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= usb_hcirq_pkg::w1c_next(q[i], clr_vec[i], set_vec[i]);
    end
  end
endmodule

// File: rtl/hcirq_irq_filter.sv
module hcirq_irq_filter
  import usb_hcirq_pkg::*;
(
  input  stat_t status,
  input  stat_t enable,
  input  logic  sg,
  output stat_t eligible,
  output logic  irq
);
  assign eligible = status & enable & irq_allow(sg);
  assign irq      = |eligible;
endmodule

// File: rtl/usb_hc_chan_irq.sv
module usb_hc_chan_irq
  import usb_hcirq_pkg::*;
#(
  parameter int ERR_LIMIT = 3,
  parameter int ADDR_W    = 2,
  parameter int STAT_IDX  = 0,
  parameter int MASK_IDX  = 1,
  localparam int CNT_W    = (ERR_LIMIT > 1) ? $clog2(ERR_LIMIT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sg_mode,
  input  logic              dma_en,
  input  logic              iso_chan,
  input  logic              ev_xfer_ok,
  input  logic              ev_desc_done,
  input  logic              ev_desc_ioc,
  input  logic              ev_desc_eol,
  input  logic              ev_halt_req,
  input  logic              ev_bus_err,
  input  logic              ev_stall,
  input  logic              ev_nak,
  input  logic              ev_ack,
  input  logic              ev_nyet,
  input  logic              ev_xact_err,
  input  logic              ev_babble,
  input  logic              ev_frm_ovr,
  input  logic              ev_tgl_err,
  input  logic              ev_desc_notready,
  input  logic              ev_list_roll,
  input  logic              ev_data_rx,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              chan_irq
);
  chan_ev_t         ev;
  stat_t            set_vec;
  stat_t            clr_vec;
  stat_t            status_q;
  stat_t            enable_q;
  stat_t            eligible;
  logic             run_hit;
  logic             handshake_ok;
  logic [CNT_W-1:0] err_cnt;
  logic             wr_stat, wr_mask;

  assign ev = '{xfer_ok: ev_xfer_ok, desc_done: ev_desc_done, desc_ioc: ev_desc_ioc,
                desc_eol: ev_desc_eol, halt_req: ev_halt_req, bus_err: ev_bus_err,
                stall: ev_stall, nak: ev_nak, ack: ev_ack, nyet: ev_nyet,
                xact_err: ev_xact_err, babble: ev_babble, frm_ovr: ev_frm_ovr,
                tgl_err: ev_tgl_err, desc_notready: ev_desc_notready,
                list_roll: ev_list_roll, data_rx: ev_data_rx};

  assign handshake_ok = ev_ack | ev_data_rx;
  assign wr_stat      = reg_we & (reg_addr == ADDR_W'(STAT_IDX));
  assign wr_mask      = reg_we & (reg_addr == ADDR_W'(MASK_IDX));
  assign clr_vec      = wr_stat ? reg_wdata[STAT_W-1:0] : '0;

  hcirq_err_counter #(.LIMIT(ERR_LIMIT)) u_errcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .err   (ev_xact_err),
    .ok    (handshake_ok),
    .hit   (run_hit),
    .cnt   (err_cnt)
  );

  hcirq_set_logic u_set (
    .ev      (ev),
    .sg      (sg_mode),
    .dma_en  (dma_en),
    .iso     (iso_chan),
    .run_hit (run_hit),
    .set_vec (set_vec)
  );

  hcirq_status_reg #(.W(STAT_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .q       (status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enable_q <= '0;
    else if (wr_mask) enable_q <= reg_wdata[STAT_W-1:0];
  end

  hcirq_irq_filter u_filt (
    .status   (status_q),
    .enable   (enable_q),
    .sg       (sg_mode),
    .eligible (eligible),
    .irq      (chan_irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(STAT_IDX))      reg_rdata[STAT_W-1:0] = read_view(sg_mode, status_q);
    else if (reg_addr == ADDR_W'(MASK_IDX)) reg_rdata[STAT_W-1:0] = enable_q;
  end
endmodule

// File: rtl/usb_hc_chan_irq_chk.sv
module usb_hc_chan_irq_chk
  import usb_hcirq_pkg::*;
#(
  parameter int ERR_LIMIT = 3,
  parameter int CNT_W     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sg_mode,
  input logic             dma_en,
  input logic             iso_chan,
  input logic             ev_ack,
  input logic             ev_data_rx,
  input logic             ev_stall,
  input stat_t            set_vec,
  input stat_t            status_q,
  input stat_t            enable_q,
  input logic [CNT_W-1:0] err_cnt,
  input logic [REG_W-1:0] reg_rdata,
  input logic             chan_irq
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:STAT_W] == '0); // R1

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R3

  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0)); // R2

  AST_SG_ONLY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !sg_mode |-> (set_vec[B_ROLL:B_BNA] == '0)); // R5

  AST_BUS_ERR_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !set_vec[B_BUSERR]); // R10

  AST_SG_PKT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_mode && ((status_q & enable_q & ~pkt_bits()) == '0)) |-> !chan_irq); // R4

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & enable_q) == '0) |-> !chan_irq); // R11

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(err_cnt) < ERR_LIMIT); // R6

  AST_CNT_CLEAR_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack || ev_data_rx) |=> (err_cnt == '0)); // R6

  AST_ISO_NO_XCS: assert property (@(posedge clk) disable iff (!rst_n)
    iso_chan |-> (!set_vec[B_XCS] && !set_vec[B_BNA])); // R7

  AST_SG_STALL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_mode && ev_stall) |-> set_vec[B_HALT]); // R8
endmodule

bind usb_hc_chan_irq usb_hc_chan_irq_chk #(.ERR_LIMIT(ERR_LIMIT), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sg_mode    (sg_mode),
  .dma_en     (dma_en),
  .iso_chan   (iso_chan),
  .ev_ack     (ev_ack),
  .ev_data_rx (ev_data_rx),
  .ev_stall   (ev_stall),
  .set_vec    (set_vec),
  .status_q   (status_q),
  .enable_q   (enable_q),
  .err_cnt    (err_cnt),
  .reg_rdata  (reg_rdata),
  .chan_irq   (chan_irq)
);

// File: tb/usb_hc_chan_irq_bench.sv
module usb_hc_chan_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sg = 1'b0, dma = 1'b0, iso = 1'b0;
  logic [16:0] ev = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [13:0] m_stat = '0;
  logic [13:0] m_mask = '0;
  int          m_run  = 0;

  always #10 clk = ~clk;

  // event vector index: 0 xfer_ok 1 desc_done 2 ioc 3 eol 4 halt 5 bus_err
  // 6 stall 7 nak 8 ack 9 nyet 10 xact 11 babble 12 frm 13 tgl 14 notready 15 roll 16 data_rx
  usb_hc_chan_irq u_usb_hc_chan_irq (
    .clk(clk), .rst_n(rst_n), .sg_mode(sg), .dma_en(dma), .iso_chan(iso),
    .ev_xfer_ok(ev[0]), .ev_desc_done(ev[1]), .ev_desc_ioc(ev[2]), .ev_desc_eol(ev[3]),
    .ev_halt_req(ev[4]), .ev_bus_err(ev[5]), .ev_stall(ev[6]), .ev_nak(ev[7]),
    .ev_ack(ev[8]), .ev_nyet(ev[9]), .ev_xact_err(ev[10]), .ev_babble(ev[11]),
    .ev_frm_ovr(ev[12]), .ev_tgl_err(ev[13]), .ev_desc_notready(ev[14]),
    .ev_list_roll(ev[15]), .ev_data_rx(ev[16]),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wd), .reg_rdata(rdata), .chan_irq(irq)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
    summary();
  end

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bench model of the event-to-set rules
  function automatic logic [13:0] model_set(input logic [16:0] e, input logic s, input logic d,
                                            input logic i, input logic run_third);
    logic [13:0] r;
    logic be, xc;
    be = e[5] && d;
    xc = s && !i && run_third;
    r = '0;
    r[0] = s ? (e[1] && e[2]) : e[0];
    r[2] = be;
    r[3] = e[6];  r[4] = e[7];  r[5] = e[8];  r[6] = e[9];
    r[7] = e[10]; r[8] = e[11]; r[9] = e[12]; r[10] = e[13];
    r[11] = s && !i && e[14];
    r[12] = xc;
    r[13] = s && e[15];
    r[1] = s ? ((e[1] && e[3]) || be || xc || e[11] || e[6]) : e[4];
    return r;
  endfunction

  task automatic check_all(input string req);
    logic [13:0] view, allow;
    view  = sg ? m_stat : {3'b000, m_stat[10:0]};
    allow = sg ? 14'b11_1000_0000_0111 : 14'b00_0111_1111_1111;
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      #1;
      case (a)
        0: cmp(req, "status read", rdata, {18'd0, view});
        1: cmp(req, "enable read", rdata, {18'd0, m_mask});
        default: cmp("R1", "unmapped read", rdata, 32'd0);
      endcase
    end
    cmp(req, "chan_irq", {31'd0, irq}, {31'd0, |(m_stat & m_mask & allow)});
  endtask

  task automatic step(input logic [16:0] e, input logic w, input logic [1:0] a,
                      input logic [31:0] d, input string req);
    logic third;
    logic [13:0] sv;
    @(negedge clk);
    ev = e; we = w; addr = a; wd = d;
    @(posedge clk);
    third = 1'b0;
    if (e[8] || e[16]) m_run = 0;
    else if (e[10]) begin
      if (m_run == 2) begin third = 1'b1; m_run = 0; end
      else m_run = m_run + 1;
    end
    sv = model_set(e, sg, dma, iso, third);
    if (w && a == 2'd0) m_stat = m_stat & ~d[13:0];
    m_stat = m_stat | sv;
    if (w && a == 2'd1) m_mask = d[13:0];
    @(negedge clk);
    ev = '0; we = 1'b0; wd = '0;
    check_all(req);
  endtask

  task automatic set_mode(input logic s, input logic d, input logic i);
    @(negedge clk);
    sg = s; dma = d; iso = i;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R2");                                    // reset state

    step('0, 1'b1, 2'd1, 32'hFFFF_FFFF, "R1");          // enable all, upper bits dropped
    step('0, 1'b1, 2'd2, 32'hFFFF_FFFF, "R1");          // unmapped write ignored
    step('0, 1'b1, 2'd3, 32'h0000_3FFF, "R1");

    // each single event in each mode combination
    for (int m = 0; m < 8; m++) begin
      set_mode(m[0], m[1], m[2]);
      for (int k = 0; k < 17; k++) begin
        step(17'(1) << k, 1'b0, 2'd0, 32'd0, "R8/R9/R10");
        step('0, 1'b1, 2'd0, 32'h0000_3FFF, "R2");
      end
    end

    // descriptor-complete flag combinations in SG and non-SG
    for (int m = 0; m < 2; m++) begin
      set_mode(m[0], 1'b1, 1'b0);
      for (int f = 0; f < 16; f++) begin
        step({13'd0, 4'(f)}, 1'b0, 2'd0, 32'd0, "R9");
        step('0, 1'b1, 2'd0, 32'h0000_3FFF, "R8");
      end
    end

    // three errors in a row, SG non-iso
    set_mode(1'b1, 1'b1, 1'b0);
    step(17'h00400, 1'b0, 2'd0, 32'd0, "R6");
    step(17'h00400, 1'b0, 2'd0, 32'd0, "R6");
    step(17'h00400, 1'b0, 2'd0, 32'd0, "R6");           // bit 12 and bit 1 set here
    step('0, 1'b1, 2'd0, 32'h0000_3FFF, "R2");
    // run broken by a handshake and by error+handshake in one cycle
    step(17'h00400, 1'b0, 2'd0, 32'd0, "R6");
    step(17'h00400, 1'b0, 2'd0, 32'd0, "R6");
    step(17'h00500, 1'b0, 2'd0, 32'd0, "R6");           // xact+ack: ack wins
    step(17'h00400, 1'b0, 2'd0, 32'd0, "R6");
    step(17'h10000, 1'b0, 2'd0, 32'd0, "R6");           // data received clears run
    step(17'h00400, 1'b0, 2'd0, 32'd0, "R6");
    step(17'h00400, 1'b0, 2'd0, 32'd0, "R6");
    step(17'h00400, 1'b0, 2'd0, 32'd0, "R6");
    step('0, 1'b1, 2'd0, 32'h0000_3FFF, "R2");

    // isochronous: no excessive-error, no buffer-not-available
    set_mode(1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) step(17'h04400, 1'b0, 2'd0, 32'd0, "R7");

    // set beats clear in the same cycle
    set_mode(1'b0, 1'b1, 1'b0);
    step(17'h00040, 1'b1, 2'd0, 32'h0000_0008, "R3");
    step(17'h00080, 1'b1, 2'd0, 32'h0000_3FFF, "R3");
    step('0, 1'b1, 2'd0, 32'd0, "R2");                  // write of zero changes nothing

    // SG keeps packet bits off the interrupt, non-SG hides SG-only bits
    set_mode(1'b1, 1'b1, 1'b0);
    step('0, 1'b1, 2'd0, 32'h0000_3FFF, "R2");
    step(17'h00080, 1'b0, 2'd0, 32'd0, "R4");
    set_mode(1'b0, 1'b1, 1'b0);
    check_all("R11");
    set_mode(1'b1, 1'b1, 1'b0);
    step(17'h08000, 1'b1, 2'd0, 32'h0000_0010, "R4");
    set_mode(1'b0, 1'b1, 1'b0);
    check_all("R5");
    step('0, 1'b1, 2'd1, 32'h0000_2000, "R11");
    step('0, 1'b1, 2'd1, 32'h0000_3FFF, "R11");

    // long mixed sweep
    for (int n = 0; n < 3000; n++) begin
      logic [16:0] e;
      logic [31:0] r;
      if (n % 50 == 0) begin
        r = $urandom;
        set_mode(r[0], r[1] | r[3], r[2] & r[4]);
      end
      e = 17'($urandom & $urandom & $urandom);
      r = $urandom;
      if (r[2:0] == 3'd0)
        step(e, 1'b1, 2'd1, $urandom, "R11");
      else if (r[3])
        step(e, 1'b1, 2'd0, $urandom | {$urandom} , "R3");
      else
        step(e, 1'b0, r[5:4], 32'd0, "R2/R5/R6");
    end

    summary();
  end
endmodule